// File: doc/BRIEF.md
# Scan Chain Flush Tester

This block checks that one scan shift register shifts correctly before any scan patterns are trusted. It contains a chain of multiplexed scan flip-flops of parameterised length. In normal mode each stage loads its functional data input on every clock. When a test is started, the controller raises the test-control select so that every stage takes its neighbour's output instead. It then drives a fixed flush stimulus into the head of the chain for the chain length plus four clocks.

The stimulus repeats 0,0,1,1, so every stage holds 0 then 0, 0 then 1, 1 then 1, and 1 then 0 during the run. The result is judged only at the serial end of the chain. The tail bit leaves through `scan_out` and returns to the block through `scan_ret`, which in a chip is the observed scan-out pad. For the first chain-length cycles the chain still holds stale data, so those cycles are not compared. In each of the last four cycles the returned bit must equal the stimulus bit driven chain-length cycles earlier. Any mismatch latches a failure.

When the run ends, `done` rises and stays high until the next start. `pass` is meaningful only while `done` is high. `cycle_cnt` reports how many shift clocks the run used, so test-time budgets can be checked against it.

Top module: `scan_flush_tester`

## Requirements
- R1: While `rst` is high at a clock edge, the run state, cycle count, fail flag and every chain stage clear. After reset `done`, `pass`, `tc`, `scan_in`, `scan_out` and `cycle_cnt` are 0.
- R2: When no run is active, `tc` is 0 and on each clock stage i loads `func_d[i]`. `scan_out` is stage CHAIN_LEN-1.
- R3: A `start` high at a clock edge while idle or done begins a run at that edge. `tc` is then 1 for exactly CHAIN_LEN+4 cycles.
- R4: In run cycle k (k = 0 first), `scan_in` equals bit 1 of k, giving the repeating stimulus 0,0,1,1.
- R5: While `tc` is 1, each clock moves `scan_in` into stage 0 and stage i-1 into stage i. In run cycle k with k >= CHAIN_LEN, `scan_out` equals the stimulus of cycle k-CHAIN_LEN.
- R6: `scan_ret` is compared with the expected bit only in run cycles CHAIN_LEN through CHAIN_LEN+3. A wrong `scan_ret` in earlier cycles does not affect `pass`.
- R7: A single compared mismatch latches a fail flag until the next start, and `pass` is then 0 when `done` is shown.
- R8: `done` rises on the clock edge that ends the last run cycle and holds until a new start is taken. `pass` is 0 whenever `done` is 0.
- R9: `cycle_cnt` equals k during run cycle k and holds CHAIN_LEN+4 while `done` is 1.
- R10: `start` during a run is ignored: the run length and the count are unchanged.
- R11: A start taken from the done state clears the fail flag, so a clean rerun after a failure reports pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a flush run (taken when not running) |
| func_d | input | CHAIN_LEN | Functional data for each stage in normal mode |
| scan_ret | input | 1 | Serial data observed back from the chain tail |
| tc | output | 1 | Test-control select, 1 = scan mode |
| scan_in | output | 1 | Flush stimulus driven into stage 0 |
| scan_out | output | 1 | Serial output of the last stage |
| done | output | 1 | Run finished, result valid |
| pass | output | 1 | No mismatch seen in the finished run |
| cycle_cnt | output | clog2(CHAIN_LEN+5) | Shift clocks used by the current or last run |

## Verification
On every cycle the embedded assertions check the following: the chain shifts one place per clock in scan mode and captures `func_d` in normal mode; the count never passes CHAIN_LEN+4 and equals it whenever `done` is high; a start during a run does not disturb the count; the fail flag stays latched within a run; and `pass` never appears without `done`. Some behaviours can only be shown by the bench's scenarios, because they depend on a whole run. These are the exact 0,0,1,1 stimulus, the delayed arrival of each bit at `scan_out`, the masking of errors in the first chain-length cycles, the detection of one flipped bit or a stuck return line, and the clean pass after a failed run.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sft_state_e;

    // Flush stimulus for a given phase within the four-cycle period: 0,0,1,1.
    function automatic logic flush_bit(input logic [1:0] phase);
        return phase[1];
    endfunction

endpackage

// File: rtl/sft_chain.sv
`timescale 1ns/1ps
module sft_chain #(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tc_i,
    input  logic                 si_i,
    input  logic [CHAIN_LEN-1:0] func_d_i,
    output logic                 so_o
);
    logic [CHAIN_LEN-1:0] stage_q;

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
            logic shift_src;
            if (i == 0) begin : g_head
                assign shift_src = si_i;
            end else begin : g_body
                assign shift_src = stage_q[i-1];
            end
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= 1'b0;
                else     stage_q[i] <= tc_i ? shift_src : func_d_i[i];
            end
        end
    endgenerate

    assign so_o = stage_q[CHAIN_LEN-1];

    // R5: scan mode moves the serial input into the head stage
    a_r5_head_shift: assert property (@(posedge clk) disable iff (rst)
        tc_i |=> stage_q[0] == $past(si_i));

    // R5: scan mode advances the tail by one place
    a_r5_tail_shift: assert property (@(posedge clk) disable iff (rst)
        tc_i |=> so_o == $past(stage_q[CHAIN_LEN-2]));

    // R2: normal mode captures the functional word
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        !tc_i |=> stage_q == $past(func_d_i));

endmodule

// File: rtl/sft_seq.sv
`timescale 1ns/1ps
module sft_seq
    import sft_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int CNT_W     = $clog2(CHAIN_LEN + 5)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             run_o,
    output logic             done_o,
    output logic             take_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int               TOTAL   = CHAIN_LEN + 4;
    localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] TOT_W   = CNT_W'(TOTAL);

    sft_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign take_o = start_i && (state_q != ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IX) state_q <= ST_DONE;
                end
                default: begin
                    if (take_o) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
            endcase
        end
    end

    assign run_o  = (state_q == ST_RUN);
    assign done_o = (state_q == ST_DONE);
    assign cnt_o  = cnt_q;

    // R9: the count never exceeds the flush length
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TOT_W);

    // R9: a finished run shows the full flush length
    a_r9_done_count: assert property (@(posedge clk) disable iff (rst)
        done_o |-> cnt_q == TOT_W);

    // R10: start while running does not restart the count
    a_r10_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (run_o && start_i) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/sft_cmp.sv
`timescale 1ns/1ps
module sft_cmp
    import sft_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int CNT_W     = $clog2(CHAIN_LEN + 5)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             done_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic             ret_i,
    output logic             pass_o
);
    localparam logic [CNT_W-1:0] LEN_W  = CNT_W'(CHAIN_LEN);
    localparam logic [1:0]       LEN_PH = 2'(CHAIN_LEN);

    logic       fail_q;
    logic       cmp_en;
    logic [1:0] exp_ph;
    logic       exp_bit;

    // Expected bit is the stimulus driven CHAIN_LEN cycles earlier.
    assign exp_ph  = idx_i[1:0] - LEN_PH;
    assign exp_bit = flush_bit(exp_ph);
    assign cmp_en  = run_i && (idx_i >= LEN_W);

    always_ff @(posedge clk) begin
        if (rst)         fail_q <= 1'b0;
        else if (clr_i)  fail_q <= 1'b0;
        else if (cmp_en && (ret_i != exp_bit)) fail_q <= 1'b1;
    end

    assign pass_o = done_i && !fail_q;

    // R7: the fail flag is sticky until a new start
    a_r7_sticky_fail: assert property (@(posedge clk) disable iff (rst)
        (fail_q && !clr_i) |=> fail_q);

    // R8: pass is only shown with done
    a_r8_pass_needs_done: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> done_i);

endmodule

// File: rtl/scan_flush_tester.sv
`timescale 1ns/1ps
module scan_flush_tester
    import sft_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    localparam int CNT_W    = $clog2(CHAIN_LEN + 5)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CHAIN_LEN-1:0] func_d,
    input  logic                 scan_ret,
    output logic                 tc,
    output logic                 scan_in,
    output logic                 scan_out,
    output logic                 done,
    output logic                 pass,
    output logic [CNT_W-1:0]     cycle_cnt
);
    logic             run_w;
    logic             take_w;
    logic [CNT_W-1:0] cnt_w;

    sft_seq #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .run_o   (run_w),
        .done_o  (done),
        .take_o  (take_w),
        .cnt_o   (cnt_w)
    );

    assign tc        = run_w;
    assign scan_in   = run_w ? flush_bit(cnt_w[1:0]) : 1'b0;
    assign cycle_cnt = cnt_w;

    sft_chain #(.CHAIN_LEN(CHAIN_LEN)) chain_i (
        .clk      (clk),
        .rst      (rst),
        .tc_i     (tc),
        .si_i     (scan_in),
        .func_d_i (func_d),
        .so_o     (scan_out)
    );

    sft_cmp #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) cmp_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run_w),
        .done_i (done),
        .clr_i  (take_w),
        .idx_i  (cnt_w),
        .ret_i  (scan_ret),
        .pass_o (pass)
    );

    // R3: scan mode and the done flag are never active together
    a_r3_tc_excl_done: assert property (@(posedge clk) disable iff (rst)
        !(tc && done));

    // R8: done holds until a start is taken
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

endmodule

// File: tb/scan_flush_tester_tb_top.sv
`timescale 1ns/1ps
module scan_flush_tester_tb_top;
    localparam int L = 8;
    localparam int T = L + 4;
    localparam int CW = $clog2(L + 5);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [L-1:0]  func_d = '0;
    logic          flip = 1'b0;
    logic          stuck_en = 1'b0;
    logic          scan_ret;
    logic          tc, scan_in, scan_out, done, pass;
    logic [CW-1:0] cycle_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // Return path: a wire from scan_out, optionally inverted or stuck at 0.
    assign scan_ret = stuck_en ? 1'b0 : (scan_out ^ flip);

    scan_flush_tester #(.CHAIN_LEN(L)) dut_i (
        .clk(clk), .rst(rst), .start(start), .func_d(func_d),
        .scan_ret(scan_ret), .tc(tc), .scan_in(scan_in),
        .scan_out(scan_out), .done(done), .pass(pass),
        .cycle_cnt(cycle_cnt)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0, "R1 done after reset", done, 0);
        chk(pass == 0, "R1 pass after reset", pass, 0);
        chk(cycle_cnt == 0, "R1 count after reset", cycle_cnt, 0);
        chk(tc == 0, "R1 tc after reset", tc, 0);
        chk(scan_in == 0, "R1 scan_in after reset", scan_in, 0);
    endtask

    task automatic t_normal();
        func_d = 8'hA5;
        @(negedge clk);
        chk(tc == 0, "R2 tc idle", tc, 0);
        chk(scan_out == 1, "R2 capture tail A5", scan_out, 1);
        func_d = 8'h5A;
        @(negedge clk);
        chk(scan_out == 0, "R2 capture tail 5A", scan_out, 0);
        func_d = 8'hFF;
        @(negedge clk);
    endtask

    // mode 0 clean, 1 errors in masked cycles, 2 one late flip,
    // 3 stuck return line, 4 start pulsed mid-run
    task automatic t_run(input int mode, input bit exp_pass, input string tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < T; k++) begin
            flip     = (mode == 1 && k < L) || (mode == 2 && k == L + 2);
            stuck_en = (mode == 3);
            start    = (mode == 4 && k == 3);
            chk(tc == 1, {"R3 tc in run ", tag}, tc, 1);
            chk(scan_in == ((k >> 1) & 1), {"R4 stimulus ", tag}, scan_in, (k >> 1) & 1);
            chk(cycle_cnt == k, {"R9 count in run ", tag}, cycle_cnt, k);
            chk(done == 0 && pass == 0, {"R8 no result in run ", tag}, {done, pass}, 0);
            if (k >= L)
                chk(scan_out == (((k - L) >> 1) & 1), {"R5 tail bit ", tag},
                    scan_out, ((k - L) >> 1) & 1);
            @(negedge clk);
        end
        flip = 1'b0; stuck_en = 1'b0; start = 1'b0;
        chk(done == 1, {"R8 done at end ", tag}, done, 1);
        chk(tc == 0, {"R3 tc drops ", tag}, tc, 0);
        chk(cycle_cnt == T, {"R9 final count ", tag}, cycle_cnt, T);
        chk(pass == exp_pass, {"R6 R7 verdict ", tag}, pass, exp_pass);
        repeat (3) @(negedge clk);
        chk(done == 1 && pass == exp_pass, {"R8 result held ", tag}, {done, pass}, {1'b1, exp_pass});
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();                          // R1
        t_normal();                         // R2
        t_run(0, 1'b1, "clean");            // R3 R4 R5 R9
        t_run(1, 1'b1, "masked");           // R6
        t_run(2, 1'b0, "oneflip");          // R7
        t_run(0, 1'b1, "rerun");            // R11
        t_run(3, 1'b0, "stuck0");           // R7
        t_run(4, 1'b1, "midstart");         // R10
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule